// File: doc/BRIEF.md
# Shared-Bus USB FIFO Endpoint Bridge

This block sits on the FPGA side of a 16-bit parallel FIFO link to a USB device controller. The data bus and its strobes are wired to several FPGAs at once. Each FPGA therefore leaves every bus line undriven unless its own chip-select is high, or unless it is still finishing a burst it has started. Words written by the controller go into an input FIFO that the application drains. Words the application produces wait in an output FIFO until the controller reads them out.

The host must request exactly as many bytes as the FPGA has queued, so the block reports the pending byte count on `out_len_o`. When a read burst starts, the block freezes that count and decrements it as words leave. When the count reaches zero it pulses a packet-end strobe, so nothing stays behind in the controller's buffers. A write burst lasts from its first word to a word flagged as last. While any burst is open the block reports busy and keeps ownership of the bus, even if chip-select drops. The ready flag falls while input FIFO space is below a threshold, which leaves room for words still in flight. A write that reaches a full input FIFO is dropped and latches a sticky error bit.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While the block is not active, `bus_ctl_oe_o`, `bus_data_oe_o`, `bus_rdy_o` and `bus_pktend_o` are 0 and `bus_data_o` is 0. The block is active when `cs_i` is high, `busy_o` is high, or a packet-end strobe is being issued.
- R2: Bus read and write strobes received while the block is inactive have no effect on either FIFO or on `out_len_o`.
- R3: While the block is active, one 16-bit word moves per clock cycle in the selected direction, with no gap cycles.
- R4: `bus_rdy_o` is 1 when the block is active and the input FIFO has at least RDY_THRESH free entries. Otherwise it is 0.
- R5: A bus write that arrives while the input FIFO is full is dropped and sets `ovf_err_o`. `ovf_err_o` stays 1 until reset.
- R6: Outside a read burst, `out_len_o` equals twice the number of words in the output FIFO, which is the count in bytes.
- R7: A read burst starts with the first accepted bus read while the output FIFO is non-empty. At that point the length is latched. It then drops by 2 for each word read, and application pushes made during the burst do not change it.
- R8: `bus_pktend_o` pulses high for exactly one cycle, in the cycle after the word that brings the latched length to zero.
- R9: `busy_o` is 1 from the cycle after a burst's first word until the burst ends. While `busy_o` is 1, the block keeps driving (`bus_ctl_oe_o`=1) even if `cs_i` is 0.
- R10: A write burst ends with the word that has `bus_wr_last_i`=1. `busy_o` is 0 in the following cycle.
- R11: After reset, both FIFOs are empty, `out_len_o`=0, `busy_o`=0 and `ovf_err_o`=0.
- R12: The input FIFO hands words to the application in bus order, using a valid/ready handshake. The output FIFO accepts application words whenever it is not full.
- R13: During a bus read, `bus_data_o` carries the oldest output FIFO word. `bus_data_oe_o` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock from the controller |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Dedicated chip-select for this FPGA |
| bus_wr_i | input | 1 | Controller presents a word for the input FIFO |
| bus_wr_last_i | input | 1 | Marks the final word of a write burst |
| bus_data_i | input | DATA_W (16) | Write data from the bus |
| bus_rd_i | input | 1 | Controller takes a word from the output FIFO |
| bus_data_o | output | DATA_W (16) | Read data to the bus |
| bus_data_oe_o | output | 1 | Data bus output enable |
| bus_ctl_oe_o | output | 1 | Output enable for the control lines |
| bus_rdy_o | output | 1 | Input FIFO has room for a burst |
| bus_pktend_o | output | 1 | End-of-read-burst strobe |
| busy_o | output | 1 | A burst is in progress |
| out_len_o | output | LEN_W (6) | Pending or remaining output bytes |
| ovf_err_o | output | 1 | Sticky input overflow flag |
| app_in_data_o | output | DATA_W (16) | Input FIFO head word |
| app_in_valid_o | output | 1 | Input FIFO holds a word |
| app_in_ready_i | input | 1 | Application takes the head word |
| app_out_data_i | input | DATA_W (16) | Word from the application |
| app_out_valid_i | input | 1 | Application offers a word |
| app_out_ready_o | output | 1 | Output FIFO can accept |

## Verification
A corrupted FIFO pointer shows up at once, on the next application handshake or bus read, as a word that breaks the scoreboard order. A wrong byte counter shows on `out_len_o` in the cycle after the pop that updates it. It also moves the packet-end pulse to a different cycle from the one the bench predicts. A burst-state flag stuck in either value changes `busy_o` and `bus_ctl_oe_o` after deselection within one cycle. That is the case most likely to cause bus contention on the shared wiring.

// File: rtl/usb_bridge_pkg.sv
package usb_bridge_pkg;
  localparam int unsigned WORD_BYTES = 2;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_IN   = 2'd1,
    DIR_OUT  = 2'd2
  } bus_dir_e;
endpackage

// File: rtl/ubr_fifo.sv
module ubr_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem[rptr_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ubr_rd_burst.sv
module ubr_rd_burst
  import usb_bridge_pkg::*;
#(
  parameter int unsigned CNT_W = 5,
  localparam int unsigned LEN_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] out_cnt_i,
  output logic             pop_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o
);
  logic             busy_q, done_q;
  logic [LEN_W-1:0] rem_q, len_now, rem_next;
  logic             start;

  assign start    = rd_i & ~busy_q & (out_cnt_i != '0);
  assign pop_o    = start | (rd_i & busy_q);
  assign len_now  = busy_q ? rem_q : {out_cnt_i, 1'b0};
  assign rem_next = len_now - LEN_W'(WORD_BYTES);
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign len_o    = len_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      done_q <= pop_o & (rem_next == '0);
      if (pop_o) begin
        rem_q  <= rem_next;
        busy_q <= (rem_next != '0);
      end
    end
  end
endmodule

// File: rtl/ubr_wr_burst.sv
module ubr_wr_burst #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned THRESH = 4,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          last_i,
  input  logic [CW-1:0] in_cnt_i,
  output logic          push_o,
  output logic          busy_o,
  output logic          ovf_o,
  output logic          room_o
);
  logic          busy_q, ovf_q, full;
  logic [CW-1:0] free_cnt;

  assign full     = (in_cnt_i == CW'(DEPTH));
  assign free_cnt = CW'(DEPTH) - in_cnt_i;
  assign push_o   = wr_i & ~full;
  assign room_o   = (free_cnt >= CW'(THRESH));
  assign busy_o   = busy_q;
  assign ovf_o    = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_i)        busy_q <= ~last_i;
      if (wr_i & full) ovf_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge
  import usb_bridge_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned IN_DEPTH   = 16,
  parameter int unsigned OUT_DEPTH  = 16,
  parameter int unsigned RDY_THRESH = 4,
  localparam int unsigned IN_CW     = $clog2(IN_DEPTH + 1),
  localparam int unsigned OUT_CW    = $clog2(OUT_DEPTH + 1),
  localparam int unsigned LEN_W     = OUT_CW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              bus_wr_i,
  input  logic              bus_wr_last_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_rd_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  output logic              bus_ctl_oe_o,
  output logic              bus_rdy_o,
  output logic              bus_pktend_o,
  output logic              busy_o,
  output logic [LEN_W-1:0]  out_len_o,
  output logic              ovf_err_o,
  output logic [DATA_W-1:0] app_in_data_o,
  output logic              app_in_valid_o,
  input  logic              app_in_ready_i,
  input  logic [DATA_W-1:0] app_out_data_i,
  input  logic              app_out_valid_i,
  output logic              app_out_ready_o
);
  logic [IN_CW-1:0]  in_cnt;
  logic [OUT_CW-1:0] out_cnt;
  logic              in_full, in_empty, out_full, out_empty;
  logic              in_push, out_pop;
  logic              wr_busy, rd_busy, rd_done, room;
  logic              active, wr_go, rd_go;
  logic [DATA_W-1:0] out_head;
  bus_dir_e          dir;

  // keep ownership until the burst and its end strobe are complete
  assign active = cs_i | wr_busy | rd_busy | rd_done;

  always_comb begin
    if (wr_busy || (bus_wr_i && !rd_busy))  dir = DIR_IN;
    else if (rd_busy || bus_rd_i)           dir = DIR_OUT;
    else                                    dir = DIR_IDLE;
  end

  assign wr_go = active & bus_wr_i & (dir == DIR_IN);
  assign rd_go = active & bus_rd_i & (dir == DIR_OUT);

  ubr_wr_burst #(.DEPTH(IN_DEPTH), .THRESH(RDY_THRESH)) u_wr (
    .clk_i, .rst_ni,
    .wr_i     (wr_go),
    .last_i   (bus_wr_last_i),
    .in_cnt_i (in_cnt),
    .push_o   (in_push),
    .busy_o   (wr_busy),
    .ovf_o    (ovf_err_o),
    .room_o   (room)
  );

  ubr_rd_burst #(.CNT_W(OUT_CW)) u_rd (
    .clk_i, .rst_ni,
    .rd_i      (rd_go),
    .out_cnt_i (out_cnt),
    .pop_o     (out_pop),
    .busy_o    (rd_busy),
    .done_o    (rd_done),
    .len_o     (out_len_o)
  );

  ubr_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_in_fifo (
    .clk_i, .rst_ni,
    .push_i  (in_push),
    .data_i  (bus_data_i),
    .pop_i   (app_in_ready_i),
    .data_o  (app_in_data_o),
    .cnt_o   (in_cnt),
    .full_o  (in_full),
    .empty_o (in_empty)
  );

  ubr_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out_fifo (
    .clk_i, .rst_ni,
    .push_i  (app_out_valid_i),
    .data_i  (app_out_data_i),
    .pop_i   (out_pop),
    .data_o  (out_head),
    .cnt_o   (out_cnt),
    .full_o  (out_full),
    .empty_o (out_empty)
  );

  assign app_in_valid_o  = ~in_empty;
  assign app_out_ready_o = ~out_full;
  assign bus_ctl_oe_o    = active;
  assign bus_data_oe_o   = active & (dir != DIR_IN) & ~out_empty;
  assign bus_data_o      = bus_data_oe_o ? out_head : '0;
  assign bus_rdy_o       = active & room & ~in_full;
  assign bus_pktend_o    = active & rd_done;
  assign busy_o          = wr_busy | rd_busy;
endmodule

// File: rtl/usb_fifo_bridge_chk.sv
module usb_fifo_bridge_chk #(
  parameter int unsigned IN_DEPTH = 16,
  parameter int unsigned LEN_W    = 6,
  localparam int unsigned IN_CW   = $clog2(IN_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_i,
  input logic             bus_wr_i,
  input logic             bus_rd_i,
  input logic             bus_data_oe_o,
  input logic             bus_ctl_oe_o,
  input logic             bus_rdy_o,
  input logic             bus_pktend_o,
  input logic             busy_o,
  input logic [LEN_W-1:0] out_len_o,
  input logic             ovf_err_o,
  input logic [IN_CW-1:0] in_cnt_i,
  input logic             rd_busy_i
);
  AST_QUIET_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && !busy_o && !bus_pktend_o) |-> (!bus_ctl_oe_o && !bus_data_oe_o && !bus_rdy_o)); // R1

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |=> ovf_err_o); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_ctl_oe_o && !rd_busy_i && in_cnt_i == IN_CW'(IN_DEPTH)) |=> (ovf_err_o && in_cnt_i <= IN_CW'(IN_DEPTH))); // R5

  AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_busy_i && !bus_rd_i) |=> $stable(out_len_o)); // R7

  AST_PKTEND_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_pktend_o |=> !bus_pktend_o); // R8

  AST_HOLD_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bus_ctl_oe_o); // R9
endmodule

bind usb_fifo_bridge usb_fifo_bridge_chk #(.IN_DEPTH(IN_DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk_i, .rst_ni, .cs_i, .bus_wr_i, .bus_rd_i, .bus_data_oe_o, .bus_ctl_oe_o,
  .bus_rdy_o, .bus_pktend_o, .busy_o, .out_len_o, .ovf_err_o,
  .in_cnt_i (in_cnt),
  .rd_busy_i(rd_busy)
);

// File: tb/usb_fifo_bridge_bench.sv
`timescale 1ns/1ps
module usb_fifo_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0, bus_wr = 1'b0, bus_last = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_din = '0, app_out_data = '0;
  logic          app_in_ready = 1'b0, app_out_valid = 1'b0;
  logic [DW-1:0] bus_dout, app_in_data;
  logic          data_oe, ctl_oe, rdy, pktend, busy, ovf, app_in_valid, app_out_ready;
  logic [LW-1:0] out_len;

  int checks = 0, errors = 0;
  int in_model = 0;
  bit done = 0;
  logic [DW-1:0] in_q[$];
  logic [DW-1:0] out_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_fifo_bridge u_usb_fifo_bridge (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs),
    .bus_wr_i(bus_wr), .bus_wr_last_i(bus_last), .bus_data_i(bus_din), .bus_rd_i(bus_rd),
    .bus_data_o(bus_dout), .bus_data_oe_o(data_oe), .bus_ctl_oe_o(ctl_oe),
    .bus_rdy_o(rdy), .bus_pktend_o(pktend), .busy_o(busy), .out_len_o(out_len),
    .ovf_err_o(ovf), .app_in_data_o(app_in_data), .app_in_valid_o(app_in_valid),
    .app_in_ready_i(app_in_ready), .app_out_data_i(app_out_data),
    .app_out_valid_i(app_out_valid), .app_out_ready_o(app_out_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: bus write, pushes expected item when the model has room
  task automatic bus_write(input logic [DW-1:0] d, input logic last);
    bus_wr = 1'b1; bus_din = d; bus_last = last;
    if (in_model < DEPTH) begin in_q.push_back(d); in_model++; end
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_last = 1'b0;
  endtask

  task automatic app_push(input logic [DW-1:0] d);
    app_out_valid = 1'b1; app_out_data = d;
    out_q.push_back(d);
    @(posedge clk); #1;
    app_out_valid = 1'b0;
  endtask

  // bus read: compare the presented word against the scoreboard head
  task automatic bus_read();
    logic [DW-1:0] exp;
    bus_rd = 1'b1;
    @(negedge clk);
    exp = out_q.pop_front();
    chk("R13 data", bus_dout, exp);
    chk("R13 oe", data_oe, 1'b1);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  // monitor: app side of the input FIFO
  always @(negedge clk) begin
    if (rst_n && app_in_valid && app_in_ready) begin
      if (in_q.size() == 0) chk("R12 unexpected word", app_in_data, 'x);
      else chk("R12 order", app_in_data, in_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R11 reset state, R1 quiet
    chk("R11 len", out_len, 0);
    chk("R11 busy", busy, 0);
    chk("R11 ovf", ovf, 0);
    chk("R11 in valid", app_in_valid, 0);
    chk("R1 ctl_oe", ctl_oe, 0);
    chk("R1 data", {data_oe, rdy, pktend, bus_dout}, 0);

    // R2: strobes while deselected
    bus_wr = 1'b1; bus_din = 16'hdead; bus_rd = 1'b1;
    repeat (3) @(posedge clk);
    #1 bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R2 no push", app_in_valid, 0);
    chk("R2 len", out_len, 0);
    chk("R1 rdy", rdy, 0);

    // write burst of 5 words, back to back
    cs = 1'b1;
    #1 chk("R4 rdy empty", rdy, 1);
    bus_write(16'h1000, 1'b0);
    chk("R9 busy", busy, 1);
    for (int i = 1; i < 4; i++) bus_write(16'h1000 + 16'(i), 1'b0);
    bus_write(16'h1004, 1'b1);
    chk("R10 burst end", busy, 0);
    // fill to 12 (free 4) then 13 (free 3)
    for (int i = 5; i < 12; i++) bus_write(16'h1000 + 16'(i), 1'b0);
    chk("R4 rdy free4", rdy, 1);
    bus_write(16'h100c, 1'b0);
    chk("R4 rdy free3", rdy, 0);
    for (int i = 13; i < 16; i++) bus_write(16'h1000 + 16'(i), 1'b0);
    chk("R5 no ovf yet", ovf, 0);
    bus_write(16'hbad0, 1'b1);
    chk("R5 ovf set", ovf, 1);
    chk("R10 end after drop", busy, 0);

    // R6 / R7 / R8 / R13 output path
    for (int i = 0; i < 5; i++) app_push(16'h2000 + 16'(i));
    chk("R6 len", out_len, 10);
    bus_read();
    chk("R7 len -2", out_len, 8);
    chk("R9 rd busy", busy, 1);
    bus_read();
    chk("R7 len -4", out_len, 6);
    app_push(16'h20aa);
    chk("R7 latched", out_len, 6);
    bus_read();
    bus_read();
    chk("R8 no pktend yet", pktend, 0);
    bus_read();
    chk("R8 pktend", pktend, 1);
    chk("R8 busy clear", busy, 0);
    @(posedge clk); #1;
    chk("R8 single pulse", pktend, 0);
    chk("R6 len extra", out_len, 2);

    // R2: read strobe while deselected
    cs = 1'b0;
    #1 chk("R1 desel oe", ctl_oe, 0);
    bus_rd = 1'b1;
    repeat (2) @(posedge clk);
    #1 bus_rd = 1'b0;
    chk("R2 rd ignored", out_len, 2);

    // R9: deselect in the middle of a read burst
    app_push(16'h20bb);
    app_push(16'h20cc);
    cs = 1'b1;
    bus_read();
    cs = 1'b0;
    #1 chk("R9 held", ctl_oe, 1);
    chk("R9 busy", busy, 1);
    bus_read();
    bus_read();
    chk("R8 pktend desel", pktend, 1);
    chk("R9 oe during pktend", ctl_oe, 1);
    @(posedge clk); #1;
    chk("R9 released", ctl_oe, 0);
    chk("R6 empty", out_len, 0);

    // drain input FIFO: R3 back-to-back words, R12 order
    app_in_ready = 1'b1;
    repeat (DEPTH + 4) @(posedge clk);
    #1 app_in_ready = 1'b0;
    chk("R3 all words delivered", in_q.size(), 0);
    chk("R12 empty", app_in_valid, 0);
    chk("R5 still set", ovf, 1);
    finish_run();
  end
endmodule